// File: doc/BRIEF.md
# XT Keyboard Serial Transmitter

This block sends scan-code bytes from a keyboard controller to a host over the two-wire XT keyboard link. Both wires are open-drain. The block never drives a wire high. It asserts a pull-down enable to make a low and releases the wire so that it floats high. The device, not the host, generates the clock. A frame is a start bit, which is the data line left released, followed by eight data bits, least significant bit first. There is no parity bit and no stop bit.

Bytes arrive through a valid/ready handshake into a one-entry holding register. The value 0xFF stands for "no key" and is never queued. Before each byte the block waits until the synchronized samples of both wires read high, which means the host is ready to receive. The byte is then copied into a shift register, so the holding register can accept the next code at once. Each bit sets up data for one half-period, then pulls the clock low for one half-period. After the eighth bit the data line is released, and a gap of two half-periods passes before the next readiness check. The half-period is `CLK_HZ / 1e6 * HALF_US` system cycles, with a default of 25 µs.

Top module: `xt_kbd_tx`

## Requirements
- R1: After reset both pull-down enables are deasserted, `busy` is low and `in_ready` is high.
- R2: `in_ready` is high exactly while the holding register is empty. A byte is accepted in the cycle `in_valid` and `in_ready` are both high.
- R3: An accepted value of 0xFF leaves the holding register empty. It produces no clock pulse, leaves `busy` low and keeps `in_ready` high.
- R4: A pending byte is not started while either synchronized line sample reads low. Nothing is pulled low during that wait, and the byte stays in the holding register.
- R5: The first clock pulse of a frame carries the start bit with data released (high). The next eight pulses carry the byte least significant bit first: a 0 bit pulls data low and a 1 bit releases it.
- R6: Before every clock pulse, data is held stable with the clock released for exactly HALF cycles. Every clock low pulse lasts exactly HALF cycles. HALF is `CLK_HZ/1000000*HALF_US`.
- R7: `busy` rises in the cycle the byte is copied. After the last clock release, data stays released and `busy` stays high for exactly 2*HALF cycles. No line is pulled while `busy` is low.
- R8: The holding register empties when the byte is copied. A second byte written during shifting is held, is not lost, and is sent next in order. A third write is refused while it waits.
- R9: Each byte produces exactly nine clock pulses, with no parity or stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Scan-code byte offered |
| in_ready | output | 1 | Holding register empty, byte can be taken |
| in_data | input | 8 | Scan-code byte |
| kclk_sense | input | 1 | Sensed level of the clock wire (asynchronous) |
| kdat_sense | input | 1 | Sensed level of the data wire (asynchronous) |
| kclk_pull | output | 1 | Pull the clock wire low when high |
| kdat_pull | output | 1 | Pull the data wire low when high |
| busy | output | 1 | A byte is being framed or the inter-byte gap is running |

## Verification
A wrong bit counter or shift register shows up on the decoded frame right after the ninth clock pulse, as a missing or extra pulse or as shuffled bits. A timer fault shows up as a wrong low-pulse or setup length within a single bit time. A stuck holding-register flag shows up at once on `in_ready`. It may also show up one frame later, as a byte that was lost or sent twice. Faults in the readiness gate or the gap timing show up in the cycle the host releases the lines or the cycle `busy` falls. The bench measures both of those cycles exactly.

// File: rtl/xt_tx_pkg.sv
package xt_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2,
        ST_GAP   = 2'd3
    } xt_state_t;

    localparam logic [7:0] NO_KEY    = 8'hFF;
    localparam int         FRAME_BITS = 9;

    function automatic int half_cycles(input int clk_hz, input int half_us);
        return (clk_hz / 1000000) * half_us;
    endfunction

endpackage

// File: rtl/xt_line_sync.sv
module xt_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/xt_hold_reg.sv
module xt_hold_reg
    import xt_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       take,
    output logic       full,
    output logic [7:0] data
);
    logic accept;
    assign in_ready = !full;
    assign accept   = in_valid && !full && (in_data != NO_KEY);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            data <= NO_KEY;
        end else if (take) begin
            full <= 1'b0;
            data <= NO_KEY;
        end else if (accept) begin
            full <= 1'b1;
            data <= in_data;
        end
    end

    assert_ff_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_data == NO_KEY) |=> in_ready);

    assert_no_loss_R8: assert property (@(posedge clk) disable iff (rst)
        (full && !take) |=> (full && $stable(data)));

    assert_take_needs_byte_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> full);
endmodule

// File: rtl/xt_tx_fsm.sv
module xt_tx_fsm
    import xt_tx_pkg::*;
#(
    parameter int HALF = 2500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    input  logic       clk_s,
    input  logic       dat_s,
    output logic       take,
    output logic       clk_low,
    output logic       dat_low,
    output logic       busy
);
    localparam int TW = $clog2(2 * HALF + 1);
    localparam logic [TW-1:0] HALF_END = TW'(HALF - 1);
    localparam logic [TW-1:0] GAP_END  = TW'(2 * HALF - 1);
    localparam logic [3:0]    LAST_BIT = 4'(FRAME_BITS - 1);

    xt_state_t   state;
    logic [TW-1:0] tmr;
    logic [3:0]    bitn;
    logic [8:0]    sh;

    assign take    = (state == ST_IDLE) && hold_full && clk_s && dat_s;
    assign busy    = (state != ST_IDLE);
    assign clk_low = (state == ST_LOW);
    assign dat_low = ((state == ST_SETUP) || (state == ST_LOW)) && !sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tmr   <= '0;
            bitn  <= '0;
            sh    <= '1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        sh    <= {hold_data, 1'b1};
                        bitn  <= '0;
                        tmr   <= '0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tmr == HALF_END) begin
                        tmr   <= '0;
                        state <= ST_LOW;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tmr == HALF_END) begin
                        tmr <= '0;
                        sh  <= {1'b1, sh[8:1]};
                        if (bitn == LAST_BIT) begin
                            state <= ST_GAP;
                        end else begin
                            bitn  <= bitn + 1'b1;
                            state <= ST_SETUP;
                        end
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_GAP: begin
                    if (tmr == GAP_END) begin
                        tmr   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!clk_low && !dat_low));

    assert_wait_ready_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(clk_s && dat_s && hold_full));

    assert_start_released_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && bitn == 4'd0) |-> !dat_low);

    assert_data_stable_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (clk_low && $past(clk_low)) |-> $stable(dat_low));
endmodule

// File: rtl/xt_kbd_tx.sv
module xt_kbd_tx
    import xt_tx_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int HALF_US = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       kclk_sense,
    input  logic       kdat_sense,
    output logic       kclk_pull,
    output logic       kdat_pull,
    output logic       busy
);
    localparam int HALF = half_cycles(CLK_HZ, HALF_US);

    logic [1:0] sensed;
    logic       hold_full;
    logic [7:0] hold_data;
    logic       take;

    xt_line_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({kdat_sense, kclk_sense}),
        .synced (sensed)
    );

    xt_hold_reg u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    xt_tx_fsm #(.HALF(HALF)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .clk_s     (sensed[0]),
        .dat_s     (sensed[1]),
        .take      (take),
        .clk_low   (kclk_pull),
        .dat_low   (kdat_pull),
        .busy      (busy)
    );
endmodule

// File: tb/tb_xt_kbd_tx.sv
module tb_xt_kbd_tx;
    localparam int HALF = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, kclk_pull, kdat_pull, busy;
    logic host_clk_rel = 1'b1, host_dat_rel = 1'b1;
    wire  line_clk = !kclk_pull && host_clk_rel;
    wire  line_dat = !kdat_pull && host_dat_rel;

    always #5 clk = ~clk;

    xt_kbd_tx #(.CLK_HZ(1_000_000), .HALF_US(HALF)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .kclk_sense(line_clk), .kdat_sense(line_dat),
        .kclk_pull(kclk_pull), .kdat_pull(kdat_pull), .busy(busy)
    );

    int checks = 0, fails = 0;
    int cyc = 0;
    // monitor state
    logic prev_clk = 0, prev_busy = 0;
    logic [8:0] bitbuf = '0;
    int nbits = 0, nframes = 0, pulses = 0;
    logic [7:0] rx [0:15];
    int bad_start = 0, bad_low = 0, bad_setup = 0, bad_gap = 0, bad_count = 0;
    int low_len = 0, hi_cnt = 0, last_rel = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (busy && !prev_busy) hi_cnt = 1;
        else if (!kclk_pull && prev_clk) begin
            hi_cnt = 1;
            if (low_len != HALF) bad_low++;
            last_rel = cyc;
        end else if (!kclk_pull) hi_cnt++;
        if (kclk_pull && !prev_clk) begin
            pulses++;
            if (hi_cnt != HALF) bad_setup++;
            bitbuf = {!kdat_pull, bitbuf[8:1]};
            nbits++;
            low_len = 1;
            if (nbits == 9) begin
                if (bitbuf[0] != 1'b1) bad_start++;
                if (nframes < 16) rx[nframes] = bitbuf[8:1];
                nframes++;
                nbits = 0;
            end
        end else if (kclk_pull) low_len++;
        if (!busy && prev_busy) begin
            if (cyc - last_rel != 2 * HALF) bad_gap++;
            if (nbits != 0) bad_count++;
        end
        prev_clk = kclk_pull;
        prev_busy = busy;
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((busy || !in_ready) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "kclk_pull after reset", kclk_pull, 0);
        check("R1", "kdat_pull after reset", kdat_pull, 0);
        check("R1", "busy after reset", busy, 0);
        check("R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_single(input logic [7:0] b);
        int f0 = nframes, p0 = pulses;
        push(b);
        check("R2", "in_ready after accept", in_ready, 0);
        wait_idle();
        check("R9", "pulses per byte", pulses - p0, 9);
        check("R5", "frames received", nframes - f0, 1);
        check("R5", "received byte", rx[f0], b);
        check("R5", "start bit released", bad_start, 0);
        check("R6", "low pulse length errors", bad_low, 0);
        check("R6", "setup length errors", bad_setup, 0);
        check("R7", "gap length errors", bad_gap, 0);
        check("R9", "partial frames at busy fall", bad_count, 0);
    endtask

    task automatic t_no_key();
        int p0 = pulses;
        push(8'hFF);
        check("R3", "in_ready after 0xFF", in_ready, 1);
        repeat (3 * HALF) @(negedge clk);
        check("R3", "pulses after 0xFF", pulses - p0, 0);
        check("R3", "busy after 0xFF", busy, 0);
    endtask

    task automatic t_host_hold();
        int p0 = pulses, f0 = nframes, n = 0;
        host_clk_rel = 1'b0;
        push(8'h5A);
        repeat (8 * HALF) @(negedge clk);
        check("R4", "busy while host holds clock", busy, 0);
        check("R4", "pulses while host holds clock", pulses - p0, 0);
        check("R4", "data pull while waiting", kdat_pull, 0);
        check("R4", "byte kept pending", in_ready, 0);
        host_clk_rel = 1'b1;
        host_dat_rel = 1'b0;
        repeat (4 * HALF) @(negedge clk);
        check("R4", "busy while host holds data", busy, 0);
        host_dat_rel = 1'b1;
        // two sync stages, then the start decision edge
        while (!busy && n < 10) begin
            @(negedge clk);
            n++;
        end
        check("R4", "cycles from release to busy", n, 3);
        check("R7", "in_ready freed with busy", in_ready, 1);
        wait_idle();
        check("R4", "held byte sent", rx[f0], 8'h5A);
    endtask

    task automatic t_back_to_back();
        int f0 = nframes;
        push(8'h81);
        while (!busy) @(negedge clk);
        check("R8", "in_ready right after copy", in_ready, 1);
        push(8'h3C);
        check("R8", "in_ready with second pending", in_ready, 0);
        @(negedge clk);
        in_valid = 1'b1;
        in_data = 8'h77;
        @(negedge clk);
        in_valid = 1'b0;
        wait_idle();
        check("R8", "frames for two bytes", nframes - f0, 2);
        check("R8", "first byte order", rx[f0], 8'h81);
        check("R8", "second byte order", rx[f0 + 1], 8'h3C);
        check("R6", "timing errors back to back", bad_low + bad_setup + bad_gap, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single(8'h1C);
        t_single(8'hA5);
        t_single(8'h00);
        t_no_key();
        t_host_hold();
        t_back_to_back();
        finish_run();
    end
endmodule